// File: doc/BRIEF.md
# Dual-Fetch Two-Way Instruction Cache

This block is a read-only instruction cache that sits between a fetch queue and a slow memory port. Each accepted fetch looks up a word address in two ways of 512 sets, with four 32-bit words per line. On a hit it hands back the addressed instruction and the one after it in the same line, one cycle after acceptance. A fetch unit that folds a taken branch out beside another instruction can therefore refill both queue slots in one cycle.

On a miss the cache requests the line from memory, starting at the missed word. It stores the beats in wrap-around order: beat k lands at word offset (first + k) mod 4. The first beat is also forwarded straight to the fetch port, so the queue restarts before the line is complete. Fetches marked cache-inhibited skip the arrays entirely. They fetch one word over the same forwarding path and leave no trace in the cache. A single-cycle invalidate input walks every set, one per cycle, and clears both valid bits.

Byte address fields: bits [3:2] select the word in the line, bits [12:4] select the set and bits [31:13] form the tag. Bits [1:0] are ignored.

Top module: `icache_dual_fetch`

## Requirements
- R1: After reset both slot valid outputs, `stall` and `mem_req_valid` are low, and no line is valid, so the first cached fetch misses.
- R2: A cached fetch that hits, accepted at a clock edge, shows `slot0_instr` = word at the address and `slot1_instr` = the following word of the same line after that edge, with `stall` low.
- R3: When the word offset is 3, `slot1_valid` is low and only `slot0_valid` is high; `slot1_valid` is never high without `slot0_valid`.
- R4: A miss raises `mem_req_valid` for exactly one cycle after the accepting edge, with `mem_req_addr` equal to the fetch address with bits [1:0] cleared and `mem_req_single` low. Memory then returns four beats in wrap order from that word.
- R5: The cycle after the first response beat, `slot0_valid` is high with that beat's data and `slot1_valid` is low.
- R6: `stall` is high from the cycle after a miss until the first beat is forwarded. During the remaining beats it is high only while `fetch_valid` is high, and such a fetch is refused.
- R7: After the fourth beat, fetches to every offset of that line hit.
- R8: A fetch with `fetch_nc` high never hits. It issues a request with `mem_req_single` high, takes one beat, forwards it on slot 0 and allocates nothing, so a later cached fetch of the same line still misses.
- R9: Refill picks an invalid way (way 0 before way 1). With both ways valid it picks the way not used most recently, where hits and fills both count as use.
- R10: `inv_all` in idle wins over a fetch in the same cycle (`stall` high, fetch dropped). `stall` then stays high for exactly 512 cycles, after which every fetch misses.
- R11: Two lines with the same set index and different tags are held at once and both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Byte address of the first instruction |
| fetch_nc | input | 1 | Fetch is cache-inhibited |
| inv_all | input | 1 | Start a full invalidation sweep |
| slot0_valid | output | 1 | First returned instruction valid |
| slot0_instr | output | 32 | First returned instruction |
| slot1_valid | output | 1 | Second returned instruction valid |
| slot1_instr | output | 32 | Second returned instruction |
| stall | output | 1 | Fetch not accepted this cycle / miss outstanding |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Word-aligned address of the first word wanted |
| mem_req_single | output | 1 | Request is for one word, not a line |
| mem_rsp_valid | input | 1 | Response beat present |
| mem_rsp_data | input | 32 | Response beat data |

## Verification
The bench targets the line-end fetch. A design that ignored the boundary would present a second instruction taken from the next set. It checks that each wrap-order beat lands at its own offset: a design that stored beats linearly would return wrong words on later hits at the offsets before the missed one. It drives three tags into one set with a hit between them, so a design that updated recency only on fills, or evicted the wrong way, misses where a hit is due. It also issues cache-inhibited fetches to cold and to cached lines, a fetch during the tail of a refill, and an invalidation that arrives together with a fetch. Each of these exposes a design that allocates bypass words, accepts work while busy, or sweeps the wrong number of cycles.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int unsigned INSTR_W  = 32;
    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TAIL = 2'd2,
        ST_INV  = 2'd3
    } fetch_fsm_e;

endpackage

// File: rtl/icache_tag_way.sv
module icache_tag_way #(
    parameter int unsigned SETS  = 512,
    parameter int unsigned TAG_W = 19,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (clr_en) valid_d[clr_idx] = 1'b0;
        if (wr_en)  valid_d[wr_idx]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);  // R7

endmodule

// File: rtl/icache_data_way.sv
module icache_data_way #(
    parameter int unsigned SETS       = 512,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned DATA_W     = 32,
    localparam int unsigned AW = $clog2(SETS) + $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_word0,
    output logic [DATA_W-1:0] rd_word1
);

    logic [DATA_W-1:0] word_mem [SETS*LINE_WORDS];
    logic [AW-1:0]     rd_addr_nx;

    assign rd_addr_nx = rd_addr + AW'(1);

    always_ff @(posedge clk) begin
        if (wr_en) word_mem[wr_addr] <= wr_data;
    end

    assign rd_word0 = word_mem[rd_addr];
    assign rd_word1 = word_mem[rd_addr_nx];

endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int unsigned SETS = 512,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_mru,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);

    logic [SETS-1:0] mru_d, mru_q;

    always_comb begin
        mru_d = mru_q;
        if (touch_en) mru_d[touch_idx] = touch_way;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mru_q <= '0;
        else        mru_q <= mru_d;
    end

    assign rd_mru = mru_q[rd_idx];

    AST_TOUCH_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (mru_q[$past(touch_idx)] == $past(touch_way)));  // R9

endmodule

// File: rtl/icache_dual_fetch.sv
module icache_dual_fetch
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SETS       = 512,
    parameter int unsigned LINE_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               fetch_nc,
    input  logic               inv_all,
    output logic               slot0_valid,
    output logic [INSTR_W-1:0] slot0_instr,
    output logic               slot1_valid,
    output logic [INSTR_W-1:0] slot1_instr,
    output logic               stall,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic               mem_req_single,
    input  logic               mem_rsp_valid,
    input  logic [INSTR_W-1:0] mem_rsp_data
);

    localparam int unsigned OFF_W = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - 2 - OFF_W - IDX_W;
    localparam int unsigned DA_W  = IDX_W + OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    typedef struct packed {
        fetch_fsm_e         fsm;
        logic [ADDR_W-1:0]  addr;
        logic               nc;
        logic [OFF_W-1:0]   beat;
        logic               way;
        logic [IDX_W-1:0]   inv_cnt;
        logic               mreq;
        logic               o0v;
        logic               o1v;
        logic [INSTR_W-1:0] o0;
        logic [INSTR_W-1:0] o1;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // request address fields
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             unused_lo;

    assign req_off   = fetch_addr[2 +: OFF_W];
    assign req_idx   = fetch_addr[2 + OFF_W +: IDX_W];
    assign req_tag   = fetch_addr[ADDR_W-1 -: TAG_W];
    assign unused_lo = ^fetch_addr[1:0];

    // captured miss address fields
    logic [OFF_W-1:0] fill_off;
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;

    assign fill_off = ctl_q.addr[2 +: OFF_W];
    assign fill_idx = ctl_q.addr[2 + OFF_W +: IDX_W];
    assign fill_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];

    // array ports
    logic [TAG_W-1:0]   way_tag   [NUM_WAYS];
    logic               way_vld   [NUM_WAYS];
    logic [INSTR_W-1:0] way_w0    [NUM_WAYS];
    logic [INSTR_W-1:0] way_w1    [NUM_WAYS];
    logic [NUM_WAYS-1:0] way_hit;

    logic               data_we;
    logic [DA_W-1:0]    data_waddr;
    logic               tag_we;
    logic               clr_en;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    logic               touch_way;
    logic               set_mru;

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WAYS; gw++) begin : g_way
            icache_tag_way #(
                .SETS  (SETS),
                .TAG_W (TAG_W)
            ) u_tag (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_idx   (req_idx),
                .rd_tag   (way_tag[gw]),
                .rd_valid (way_vld[gw]),
                .wr_en    (tag_we && (ctl_q.way == 1'(gw))),
                .wr_idx   (fill_idx),
                .wr_tag   (fill_tag),
                .clr_en   (clr_en),
                .clr_idx  (ctl_q.inv_cnt)
            );

            icache_data_way #(
                .SETS       (SETS),
                .LINE_WORDS (LINE_WORDS),
                .DATA_W     (INSTR_W)
            ) u_data (
                .clk      (clk),
                .wr_en    (data_we && (ctl_q.way == 1'(gw))),
                .wr_addr  (data_waddr),
                .wr_data  (mem_rsp_data),
                .rd_addr  ({req_idx, req_off}),
                .rd_word0 (way_w0[gw]),
                .rd_word1 (way_w1[gw])
            );

            assign way_hit[gw] = way_vld[gw] && (way_tag[gw] == req_tag);
        end
    endgenerate

    icache_lru #(
        .SETS (SETS)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (req_idx),
        .rd_mru    (set_mru),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way)
    );

    logic               any_hit;
    logic               hit_way;
    logic [INSTR_W-1:0] hit_w0;
    logic [INSTR_W-1:0] hit_w1;
    logic               victim;

    assign any_hit = |way_hit;
    assign hit_way = way_hit[1];
    assign hit_w0  = hit_way ? way_w0[1] : way_w0[0];
    assign hit_w1  = hit_way ? way_w1[1] : way_w1[0];
    assign victim  = !way_vld[0] ? 1'b0 : (!way_vld[1] ? 1'b1 : !set_mru);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mreq = 1'b0;
        ctl_d.o0v  = 1'b0;
        ctl_d.o1v  = 1'b0;
        data_we    = 1'b0;
        data_waddr = {fill_idx, fill_off + ctl_q.beat};
        tag_we     = 1'b0;
        clr_en     = 1'b0;
        touch_en   = 1'b0;
        touch_idx  = req_idx;
        touch_way  = hit_way;
        case (ctl_q.fsm)
            ST_IDLE: begin
                if (inv_all) begin
                    ctl_d.fsm     = ST_INV;
                    ctl_d.inv_cnt = '0;
                end else if (fetch_valid) begin
                    if (!fetch_nc && any_hit) begin
                        ctl_d.o0v = 1'b1;
                        ctl_d.o0  = hit_w0;
                        ctl_d.o1v = (req_off != LAST_OFF);
                        ctl_d.o1  = hit_w1;
                        touch_en  = 1'b1;
                    end else begin
                        ctl_d.fsm  = ST_WAIT;
                        ctl_d.addr = {fetch_addr[ADDR_W-1:2], 2'b00};
                        ctl_d.nc   = fetch_nc;
                        ctl_d.beat = '0;
                        ctl_d.way  = victim;
                        ctl_d.mreq = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    ctl_d.o0v = 1'b1;
                    ctl_d.o0  = mem_rsp_data;
                    if (ctl_q.nc) begin
                        ctl_d.fsm = ST_IDLE;
                    end else begin
                        data_we    = 1'b1;
                        ctl_d.beat = ctl_q.beat + OFF_W'(1);
                        ctl_d.fsm  = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (mem_rsp_valid) begin
                    data_we    = 1'b1;
                    ctl_d.beat = ctl_q.beat + OFF_W'(1);
                    if (ctl_q.beat == LAST_OFF) begin
                        tag_we    = 1'b1;
                        touch_en  = 1'b1;
                        touch_idx = fill_idx;
                        touch_way = ctl_q.way;
                        ctl_d.fsm = ST_IDLE;
                    end
                end
            end
            ST_INV: begin
                clr_en        = 1'b1;
                ctl_d.inv_cnt = ctl_q.inv_cnt + IDX_W'(1);
                if (ctl_q.inv_cnt == LAST_SET) ctl_d.fsm = ST_IDLE;
            end
            default: ctl_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign slot0_valid    = ctl_q.o0v;
    assign slot0_instr    = ctl_q.o0;
    assign slot1_valid    = ctl_q.o1v;
    assign slot1_instr    = ctl_q.o1;
    assign mem_req_valid  = ctl_q.mreq;
    assign mem_req_addr   = ctl_q.addr;
    assign mem_req_single = ctl_q.nc;
    assign stall = (ctl_q.fsm == ST_WAIT) || (ctl_q.fsm == ST_INV)
                || ((ctl_q.fsm == ST_IDLE) && inv_all)
                || ((ctl_q.fsm == ST_TAIL) && fetch_valid);

    AST_PAIR_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_valid |-> slot0_valid);  // R3

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);  // R4

    AST_CRIT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == ST_WAIT && mem_rsp_valid)
        |=> (slot0_valid && !slot1_valid && slot0_instr == $past(mem_rsp_data)));  // R5

    AST_MISS_HOLDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == ST_WAIT && !mem_rsp_valid) |=> stall);  // R6

    AST_BYPASS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == ST_WAIT && ctl_q.nc) |-> (!tag_we && !data_we));  // R8

    AST_SWEEP_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == ST_INV && ctl_q.inv_cnt != LAST_SET) |=> (ctl_q.fsm == ST_INV));  // R10

endmodule

// File: tb/icache_dual_fetch_tb.sv
module icache_dual_fetch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_nc = 1'b0;
    logic        inv_all = 1'b0;
    logic        slot0_valid, slot1_valid, stall;
    logic [31:0] slot0_instr, slot1_instr;
    logic        mem_req_valid, mem_req_single;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;

    bit          ref_v [2][NSETS];
    logic [18:0] ref_t [2][NSETS];
    bit          ref_m [NSETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_dual_fetch u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .fetch_nc       (fetch_nc),
        .inv_all        (inv_all),
        .slot0_valid    (slot0_valid),
        .slot0_instr    (slot0_instr),
        .slot1_valid    (slot1_valid),
        .slot1_instr    (slot1_instr),
        .stall          (stall),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_req_single (mem_req_single),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data)
    );

    function automatic logic [31:0] mword(input logic [31:0] byte_addr);
        logic [31:0] wa;
        wa = byte_addr >> 2;
        return (wa * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    function automatic logic [31:0] mk(input int tg, input int ix, input int off);
        return {19'(tg), 9'(ix), 2'(off), 2'b00};
    endfunction

    function automatic int ref_hit_way(input logic [31:0] a);
        for (int w = 0; w < 2; w++)
            if (ref_v[w][a[12:4]] && ref_t[w][a[12:4]] == a[31:13]) return w;
        return -1;
    endfunction

    function automatic int ref_victim(input logic [31:0] a);
        if (!ref_v[0][a[12:4]]) return 0;
        if (!ref_v[1][a[12:4]]) return 1;
        return ref_m[a[12:4]] ? 0 : 1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ref_clear();
        for (int s = 0; s < NSETS; s++) begin
            ref_v[0][s] = 1'b0;
            ref_v[1][s] = 1'b0;
            ref_m[s]    = 1'b0;
        end
    endtask

    // one fetch, including the memory side if it misses; probe tests a tail-time request
    task automatic fetch(input logic [31:0] a, input bit nc, input bit probe, output bit hit_seen);
        int          exp_way;
        int          vic;
        bit          exp_hit;
        int          nbeats;
        logic [31:0] base;
        logic [31:0] ba;
        exp_way = ref_hit_way(a);
        exp_hit = !nc && (exp_way >= 0);
        vic     = ref_victim(a);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        fetch_nc    = nc;
        @(negedge clk);
        hit_seen = slot0_valid && !stall;
        fetch_valid = 1'b0;
        if (exp_hit) begin
            chk(hit_seen, "R2 hit expected", 32'(hit_seen), 1);
            chk(slot0_instr == mword(a), "R2 slot0 data", slot0_instr, mword(a));
            chk(slot1_valid == (a[3:2] != 2'd3), "R3 slot1 valid", 32'(slot1_valid), 32'(a[3:2] != 2'd3));
            if (a[3:2] != 2'd3)
                chk(slot1_instr == mword(a + 4), "R2 slot1 data", slot1_instr, mword(a + 4));
            ref_m[a[12:4]] = exp_way[0];
        end else begin
            chk(!hit_seen && stall, "R6 stall after miss", 32'(stall), 1);
            chk(mem_req_valid, "R4 request pulse", 32'(mem_req_valid), 1);
            chk(mem_req_addr == {a[31:2], 2'b00}, "R4 request address", mem_req_addr, {a[31:2], 2'b00});
            chk(mem_req_single == nc, "R8 single flag", 32'(mem_req_single), 32'(nc));
        end
        if (stall) begin
            nbeats = mem_req_single ? 1 : 4;
            base   = {a[31:4], 4'h0};
            for (int k = 0; k < nbeats; k++) begin
                int gap;
                gap = int'($urandom % 3);
                for (int g = 0; g < gap; g++) begin
                    if (k == 0) chk(stall, "R6 stall held", 32'(stall), 1);
                    @(negedge clk);
                end
                ba = base + {28'h0, 2'(a[3:2] + 2'(k)), 2'b00};
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mword(ba);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                if (k == 0) begin
                    chk(slot0_valid && slot0_instr == mword(a), "R5 forwarded word", slot0_instr, mword(a));
                    chk(!slot1_valid, "R5 slot1 low", 32'(slot1_valid), 0);
                    chk(!stall, "R6 stall drops", 32'(stall), 0);
                end else begin
                    chk(!slot0_valid, "R5 tail not forwarded", 32'(slot0_valid), 0);
                end
                if (probe && k == 1) begin
                    fetch_valid = 1'b1;
                    fetch_addr  = a;
                    #1;
                    chk(stall, "R6 tail refuses fetch", 32'(stall), 1);
                    fetch_valid = 1'b0;
                    #1;
                    chk(!stall, "R6 tail idle no stall", 32'(stall), 0);
                end
            end
            if (!exp_hit && !nc) begin
                ref_v[vic][a[12:4]] = 1'b1;
                ref_t[vic][a[12:4]] = a[31:13];
                ref_m[a[12:4]]      = vic[0];
            end
        end
    endtask

    task automatic sweep(input bit with_fetch, input logic [31:0] a);
        int cnt;
        @(negedge clk);
        inv_all     = 1'b1;
        fetch_valid = with_fetch;
        fetch_addr  = a;
        fetch_nc    = 1'b0;
        #1;
        chk(stall, "R10 invalidate wins", 32'(stall), 1);
        @(negedge clk);
        inv_all     = 1'b0;
        fetch_valid = 1'b0;
        chk(!slot0_valid && !mem_req_valid, "R10 fetch dropped", 32'(slot0_valid), 0);
        cnt = 0;
        while (stall && cnt < 2000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == NSETS, "R10 sweep length", 32'(cnt), NSETS);
        ref_clear();
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit          h;
        logic [31:0] A, B, C, D;
        void'($urandom(32'h1CAC4E));
        ref_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!slot0_valid && !slot1_valid, "R1 slots low", {slot0_valid, slot1_valid}, 0);
        chk(!stall && !mem_req_valid, "R1 stall and request low", {stall, mem_req_valid}, 0);

        A = mk(1, 7, 1);
        B = mk(2, 7, 0);
        C = mk(3, 7, 2);
        D = mk(5, 20, 2);

        fetch(A, 1'b0, 1'b0, h);
        chk(!h, "R1 cold miss", 32'(h), 0);
        for (int o = 0; o < 4; o++) begin
            fetch(mk(1, 7, o), 1'b0, 1'b0, h);
            chk(h, "R7 whole line hits", 32'(h), 1);
        end
        fetch(B, 1'b0, 1'b1, h);
        chk(!h, "R11 second tag misses", 32'(h), 0);
        fetch(A, 1'b0, 1'b0, h);
        chk(h, "R11 first tag kept", 32'(h), 1);
        fetch(B, 1'b0, 1'b0, h);
        chk(h, "R11 second tag kept", 32'(h), 1);
        fetch(A, 1'b0, 1'b0, h);
        fetch(C, 1'b0, 1'b0, h);
        chk(!h, "R9 third tag misses", 32'(h), 0);
        fetch(A, 1'b0, 1'b0, h);
        chk(h, "R9 recently used line kept", 32'(h), 1);
        fetch(B, 1'b0, 1'b0, h);
        chk(!h, "R9 older line evicted", 32'(h), 0);

        fetch(D, 1'b1, 1'b0, h);
        chk(!h, "R8 bypass fetch", 32'(h), 0);
        fetch(D, 1'b0, 1'b0, h);
        chk(!h, "R8 bypass did not allocate", 32'(h), 0);
        fetch(A, 1'b1, 1'b0, h);
        chk(!h, "R8 bypass ignores cached line", 32'(h), 0);
        fetch(A, 1'b0, 1'b0, h);
        chk(h, "R8 cached line untouched", 32'(h), 1);

        sweep(1'b1, A);
        fetch(A, 1'b0, 1'b0, h);
        chk(!h, "R10 miss after invalidate", 32'(h), 0);

        for (int i = 0; i < 300; i++) begin
            int tg, ix, off;
            bit nc;
            tg  = int'($urandom % 3);
            ix  = (int'($urandom % 4) == 0) ? 511 : int'($urandom % 3);
            off = int'($urandom % 4);
            nc  = (($urandom % 8) == 0);
            if (($urandom % 150) == 0) sweep(1'b0, '0);
            fetch(mk(tg, ix, off), nc, (($urandom % 5) == 0), h);
        end

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule